// File: doc/BRIEF.md
# Debug Mode Entry Controller

This block decides when a single-wire background debug unit may be used and when the CPU is sent into debug mode. It holds two status bits, a debug-enable bit and an unsecure bit. The host changes the enable bit through a small register write port. The block takes three kinds of activation request: a background command from the host, a background instruction executed by the CPU, and a request from a breakpoint comparator. When enabled, it turns these requests into a single entry event. That event takes effect only at the next instruction boundary, and the block saves the program counter at that point for the debug firmware.

After a secured reset into special single-chip mode, the block waits for the erase-verify result from the nonvolatile memories. If both memories are blank, it unlocks every command class. Otherwise it unlocks only hardware-level commands, so the host can still erase the memories. On a secured device in any other mode, the debug unit stays off.

The block also decodes the debug address window. Its low twelve locations hold the debug registers and the rest holds the firmware table. While debug mode is active, the block blocks user-program reads of the whole window.

Top module: `dbg_entry_ctrl`

## Requirements
- R1: After reset with `special_mode`=1 and `secured`=0, the outputs `dbg_active`, `dbg_enabled` and `fw_cmd_ok` are 1. After reset with `special_mode`=0 and `secured`=0, `dbg_active`, `dbg_enabled`, `cpu_stall` and `enter_pulse` are 0.
- R2: A write with `reg_wr_addr`=0x1 copies `reg_wr_data` bit 7 into the enable bit, and `dbg_enabled` shows the new value after the clock edge. A write to any other offset leaves the enable bit unchanged. Data bit 6 never changes `unsec_bit`.
- R3: While the unit is disabled (`hw_cmd_ok`=0), `host_bgnd` and `brk_req` are dropped. They cause no stall and no activation, even when `insn_done`=1.
- R4: A `cpu_bgnd` request while the unit is disabled and inactive raises `cpu_stall` for exactly STALL_CYC cycles (16 by default), starting after the next edge. It does not activate the unit.
- R5: When the unit is enabled, an activation request is held pending until a cycle with `insn_done`=1. After that edge, `dbg_active` becomes 1 and `enter_pulse` is 1 for one cycle.
- R6: Requests arriving in the same cycle produce one entry pulse. Requests made while `dbg_active`=1 produce no further pulse.
- R7: At entry, `saved_pc` takes `cpu_pc`+1 when `cpu_pc` lies in the firmware range 0x3FF0C..0x3FFFF, and takes `cpu_pc` otherwise.
- R8: After a secured special reset, `dbg_enabled`=0 and `hw_cmd_ok`=0 until `ev_done`. If `ev_done` arrives with both pass flags at 1, `dbg_enabled`, `unsec_bit` and `fw_cmd_ok` become 1.
- R9: If `ev_done` arrives on a secured special reset with either pass flag at 0, `dbg_enabled`=1, `unsec_bit`=0, `hw_cmd_ok`=1 and `fw_cmd_ok`=0. `host_go` then does not leave debug mode.
- R10: On a secured device with `special_mode`=0, `dbg_enabled` and `hw_cmd_ok` stay 0, host writes to the enable bit are ignored, and activation requests are dropped.
- R11: `user_rd_block` is 1 when `user_rd_en`=1, `dbg_active`=1 and `user_rd_addr` is in 0x3FF00..0x3FFFF. It is 0 otherwise.
- R12: `dbg_reg_hit` is 1 exactly when `dbg_rd_addr` is in 0x3FF00..0x3FF0B.
- R13: `host_go` while `fw_cmd_ok`=1 clears `dbg_active` after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| secured | input | 1 | Device security strap |
| special_mode | input | 1 | Special single-chip mode strap |
| ev_done | input | 1 | Erase-verify result valid |
| ev_ok_eeprom | input | 1 | EEPROM verified blank |
| ev_ok_flash | input | 1 | Flash verified blank |
| reg_wr_en | input | 1 | Host register write strobe |
| reg_wr_addr | input | 4 | Host register offset |
| reg_wr_data | input | 8 | Host register write data |
| host_bgnd | input | 1 | Host background command |
| cpu_bgnd | input | 1 | CPU background instruction executed |
| brk_req | input | 1 | Breakpoint activation request |
| insn_done | input | 1 | Current instruction completes this cycle |
| host_go | input | 1 | Host resume command |
| cpu_pc | input | 18 | CPU program counter |
| user_rd_en | input | 1 | User-program read strobe |
| user_rd_addr | input | 18 | User-program read address |
| dbg_rd_addr | input | 18 | Debug-side read address |
| dbg_enabled | output | 1 | Enable status bit |
| unsec_bit | output | 1 | Unsecure status bit |
| dbg_active | output | 1 | Debug mode active |
| enter_pulse | output | 1 | One-cycle debug entry event |
| cpu_stall | output | 1 | CPU held by disabled background instruction |
| hw_cmd_ok | output | 1 | Hardware commands permitted |
| fw_cmd_ok | output | 1 | Firmware commands permitted |
| saved_pc | output | 18 | Program counter saved at entry |
| user_rd_block | output | 1 | User read of debug window refused |
| dbg_reg_hit | output | 1 | Debug read hits the register block |

## Verification
The assertions check several rules on every cycle. An entry can happen only at an instruction boundary and only while enabled. Each entry pulse lasts exactly one cycle. Firmware permission never appears without hardware permission. A secured device outside special mode stays off, and a user read is blocked only while debug mode is active. Some behaviours need the bench's scenarios instead: the exact stall length, holding a request pending across several cycles, the saved program counter at the range edges, and the two erase-verify outcomes.

// File: rtl/dbg_entry_pkg.sv
package dbg_entry_pkg;
    localparam int unsigned REG_AW     = 4;
    localparam int unsigned REG_DW     = 8;
    localparam int unsigned STS_OFS    = 1;
    localparam int unsigned ENA_BIT    = 7;

    typedef struct packed {
        logic enable;
        logic unsec;
        logic ev_seen;
    } sec_state_t;
endpackage

// File: rtl/dbg_sec_policy.sv
module dbg_sec_policy
    import dbg_entry_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              secured,
    input  logic              special_mode,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [REG_DW-1:0] wr_data,
    input  logic              ev_done,
    input  logic              ev_ok_eeprom,
    input  logic              ev_ok_flash,
    output logic              enable,
    output logic              unsec,
    output logic              hw_ok,
    output logic              fw_unlocked
);
    sec_state_t st_d, st_q;
    logic       wr_allowed;
    logic       sts_hit;

    always_comb begin
        st_d       = st_q;
        wr_allowed = !secured || (special_mode && st_q.ev_seen);
        sts_hit    = wr_en && (wr_addr == REG_AW'(STS_OFS));
        if (secured && special_mode && ev_done && !st_q.ev_seen) begin
            st_d.ev_seen = 1'b1;
            st_d.enable  = 1'b1;
            st_d.unsec   = ev_ok_eeprom && ev_ok_flash;
        end else if (sts_hit && wr_allowed) begin
            st_d.enable = wr_data[ENA_BIT];
        end
        if (secured && !special_mode) begin
            st_d.enable = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.enable  <= special_mode && !secured;
            st_q.unsec   <= 1'b0;
            st_q.ev_seen <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign enable      = st_q.enable;
    assign unsec       = st_q.unsec;
    assign hw_ok       = st_q.enable && (!secured || special_mode);
    assign fw_unlocked = !secured || st_q.unsec;
endmodule

// File: rtl/dbg_act_ctrl.sv
module dbg_act_ctrl #(
    parameter int unsigned AW        = 18,
    parameter int unsigned STALL_CYC = 16,
    parameter int unsigned FW_LO     = 32'h3FF0C,
    parameter int unsigned FW_HI     = 32'h3FFFF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          special_mode,
    input  logic          hw_ok,
    input  logic          fw_unlocked,
    input  logic          host_bgnd,
    input  logic          cpu_bgnd,
    input  logic          brk_req,
    input  logic          insn_done,
    input  logic          host_go,
    input  logic [AW-1:0] cpu_pc,
    output logic          active,
    output logic          enter,
    output logic          stall,
    output logic [AW-1:0] saved_pc
);
    localparam int unsigned CW = $clog2(STALL_CYC + 1);
    localparam logic [AW-1:0] LO = AW'(FW_LO);
    localparam logic [AW-1:0] HI = AW'(FW_HI);

    typedef struct packed {
        logic          active;
        logic          pending;
        logic          enter;
        logic [CW-1:0] cnt;
        logic [AW-1:0] spc;
    } act_state_t;

    act_state_t st_d, st_q;
    logic       any_req;
    logic       take;
    logic       in_fw;

    always_comb begin
        st_d       = st_q;
        st_d.enter = 1'b0;
        any_req    = host_bgnd || cpu_bgnd || brk_req;
        take       = any_req && hw_ok && !st_q.active;
        in_fw      = (cpu_pc >= LO) && (cpu_pc <= HI);

        if (st_q.active) begin
            st_d.pending = 1'b0;
            if (host_go && hw_ok && fw_unlocked) begin
                st_d.active = 1'b0;
            end
        end else if ((st_q.pending || take) && hw_ok) begin
            if (insn_done) begin
                st_d.active  = 1'b1;
                st_d.enter   = 1'b1;
                st_d.pending = 1'b0;
                st_d.spc     = in_fw ? cpu_pc + AW'(1) : cpu_pc;
            end else begin
                st_d.pending = 1'b1;
            end
        end else begin
            st_d.pending = 1'b0;
        end

        if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - CW'(1);
        end
        if (cpu_bgnd && !hw_ok && !st_q.active) begin
            st_d.cnt = CW'(STALL_CYC);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.active  <= special_mode;
            st_q.pending <= 1'b0;
            st_q.enter   <= 1'b0;
            st_q.cnt     <= '0;
            st_q.spc     <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active   = st_q.active;
    assign enter    = st_q.enter;
    assign stall    = (st_q.cnt != '0);
    assign saved_pc = st_q.spc;
endmodule

// File: rtl/dbg_addr_win.sv
module dbg_addr_win #(
    parameter int unsigned AW       = 18,
    parameter int unsigned WIN_BASE = 32'h3FF00,
    parameter int unsigned WIN_SIZE = 256,
    parameter int unsigned REG_CNT  = 12
) (
    input  logic          active,
    input  logic          user_rd_en,
    input  logic [AW-1:0] user_rd_addr,
    input  logic [AW-1:0] dbg_rd_addr,
    output logic          user_rd_block,
    output logic          dbg_reg_hit
);
    localparam logic [AW-1:0] WIN_LO = AW'(WIN_BASE);
    localparam logic [AW-1:0] WIN_HI = AW'(WIN_BASE + WIN_SIZE - 1);
    localparam logic [AW-1:0] REG_HI = AW'(WIN_BASE + REG_CNT - 1);

    logic user_in_win;

    always_comb begin
        user_in_win   = (user_rd_addr >= WIN_LO) && (user_rd_addr <= WIN_HI);
        user_rd_block = user_rd_en && active && user_in_win;
        dbg_reg_hit   = (dbg_rd_addr >= WIN_LO) && (dbg_rd_addr <= REG_HI);
    end
endmodule

// File: rtl/dbg_entry_ctrl.sv
module dbg_entry_ctrl
    import dbg_entry_pkg::*;
#(
    parameter int unsigned AW        = 18,
    parameter int unsigned STALL_CYC = 16,
    parameter int unsigned WIN_BASE  = 32'h3FF00,
    parameter int unsigned WIN_SIZE  = 256,
    parameter int unsigned REG_CNT   = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              secured,
    input  logic              special_mode,
    input  logic              ev_done,
    input  logic              ev_ok_eeprom,
    input  logic              ev_ok_flash,
    input  logic              reg_wr_en,
    input  logic [REG_AW-1:0] reg_wr_addr,
    input  logic [REG_DW-1:0] reg_wr_data,
    input  logic              host_bgnd,
    input  logic              cpu_bgnd,
    input  logic              brk_req,
    input  logic              insn_done,
    input  logic              host_go,
    input  logic [AW-1:0]     cpu_pc,
    input  logic              user_rd_en,
    input  logic [AW-1:0]     user_rd_addr,
    input  logic [AW-1:0]     dbg_rd_addr,
    output logic              dbg_enabled,
    output logic              unsec_bit,
    output logic              dbg_active,
    output logic              enter_pulse,
    output logic              cpu_stall,
    output logic              hw_cmd_ok,
    output logic              fw_cmd_ok,
    output logic [AW-1:0]     saved_pc,
    output logic              user_rd_block,
    output logic              dbg_reg_hit
);
    localparam int unsigned FW_LO = WIN_BASE + REG_CNT;
    localparam int unsigned FW_HI = WIN_BASE + WIN_SIZE - 1;

    logic hw_ok;
    logic fw_unlocked;

    dbg_sec_policy i_sec (
        .clk          (clk),
        .rst_n        (rst_n),
        .secured      (secured),
        .special_mode (special_mode),
        .wr_en        (reg_wr_en),
        .wr_addr      (reg_wr_addr),
        .wr_data      (reg_wr_data),
        .ev_done      (ev_done),
        .ev_ok_eeprom (ev_ok_eeprom),
        .ev_ok_flash  (ev_ok_flash),
        .enable       (dbg_enabled),
        .unsec        (unsec_bit),
        .hw_ok        (hw_ok),
        .fw_unlocked  (fw_unlocked)
    );

    dbg_act_ctrl #(
        .AW        (AW),
        .STALL_CYC (STALL_CYC),
        .FW_LO     (FW_LO),
        .FW_HI     (FW_HI)
    ) i_act (
        .clk          (clk),
        .rst_n        (rst_n),
        .special_mode (special_mode),
        .hw_ok        (hw_ok),
        .fw_unlocked  (fw_unlocked),
        .host_bgnd    (host_bgnd),
        .cpu_bgnd     (cpu_bgnd),
        .brk_req      (brk_req),
        .insn_done    (insn_done),
        .host_go      (host_go),
        .cpu_pc       (cpu_pc),
        .active       (dbg_active),
        .enter        (enter_pulse),
        .stall        (cpu_stall),
        .saved_pc     (saved_pc)
    );

    dbg_addr_win #(
        .AW       (AW),
        .WIN_BASE (WIN_BASE),
        .WIN_SIZE (WIN_SIZE),
        .REG_CNT  (REG_CNT)
    ) i_win (
        .active        (dbg_active),
        .user_rd_en    (user_rd_en),
        .user_rd_addr  (user_rd_addr),
        .dbg_rd_addr   (dbg_rd_addr),
        .user_rd_block (user_rd_block),
        .dbg_reg_hit   (dbg_reg_hit)
    );

    assign hw_cmd_ok = hw_ok;
    assign fw_cmd_ok = dbg_active && hw_ok && fw_unlocked;
endmodule

// File: rtl/dbg_entry_chk.sv
module dbg_entry_chk (
    input logic clk,
    input logic rst_n,
    input logic secured,
    input logic special_mode,
    input logic insn_done,
    input logic user_rd_en,
    input logic dbg_enabled,
    input logic unsec_bit,
    input logic dbg_active,
    input logic enter_pulse,
    input logic hw_cmd_ok,
    input logic fw_cmd_ok,
    input logic user_rd_block
);
    AST_ENTER_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        enter_pulse |-> $past(insn_done)); // R5
    AST_RISE_HAS_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dbg_active) |-> enter_pulse); // R5
    AST_ENTER_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        enter_pulse |=> !enter_pulse); // R6
    AST_ENTER_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        enter_pulse |-> $past(hw_cmd_ok)); // R3
    AST_FW_NEEDS_HW: assert property (@(posedge clk) disable iff (!rst_n)
        fw_cmd_ok |-> (hw_cmd_ok && dbg_active)); // R9
    AST_SECURE_NORMAL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (secured && !special_mode) |-> (!dbg_enabled && !hw_cmd_ok)); // R10
    AST_UNSEC_ONLY_SECURED: assert property (@(posedge clk) disable iff (!rst_n)
        !secured |-> !unsec_bit); // R8
    AST_USER_BLOCK_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        user_rd_block |-> (dbg_active && user_rd_en)); // R11
endmodule

bind dbg_entry_ctrl dbg_entry_chk i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .secured       (secured),
    .special_mode  (special_mode),
    .insn_done     (insn_done),
    .user_rd_en    (user_rd_en),
    .dbg_enabled   (dbg_enabled),
    .unsec_bit     (unsec_bit),
    .dbg_active    (dbg_active),
    .enter_pulse   (enter_pulse),
    .hw_cmd_ok     (hw_cmd_ok),
    .fw_cmd_ok     (fw_cmd_ok),
    .user_rd_block (user_rd_block)
);

// File: tb/test_dbg_entry_ctrl.sv
module test_dbg_entry_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        secured = 1'b0, special_mode = 1'b0;
    logic        ev_done = 1'b0, ev_ok_eeprom = 1'b0, ev_ok_flash = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [3:0]  reg_wr_addr = '0;
    logic [7:0]  reg_wr_data = '0;
    logic        host_bgnd = 1'b0, cpu_bgnd = 1'b0, brk_req = 1'b0;
    logic        insn_done = 1'b0, host_go = 1'b0;
    logic [17:0] cpu_pc = '0;
    logic        user_rd_en = 1'b0;
    logic [17:0] user_rd_addr = '0, dbg_rd_addr = '0;
    logic        dbg_enabled, unsec_bit, dbg_active, enter_pulse, cpu_stall;
    logic        hw_cmd_ok, fw_cmd_ok, user_rd_block, dbg_reg_hit;
    logic [17:0] saved_pc;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dbg_entry_ctrl i_dbg_entry_ctrl (.*);

    // {address, expected register hit, expected user block while active}
    localparam logic [19:0] VEC [8] = '{
        {18'h3FEFF, 1'b0, 1'b0},
        {18'h3FF00, 1'b1, 1'b1},
        {18'h3FF05, 1'b1, 1'b1},
        {18'h3FF0B, 1'b1, 1'b1},
        {18'h3FF0C, 1'b0, 1'b1},
        {18'h3FFFF, 1'b0, 1'b1},
        {18'h00000, 1'b0, 1'b0},
        {18'h1FF05, 1'b0, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset(input logic sec, input logic spc);
        secured = sec;
        special_mode = spc;
        rst_n = 1'b0;
        step();
        step();
        rst_n = 1'b1;
    endtask

    task automatic wr_sts(input logic [3:0] a, input logic [7:0] d);
        reg_wr_en = 1'b1;
        reg_wr_addr = a;
        reg_wr_data = d;
        step();
        reg_wr_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1 special unsecured reset: enabled and active
        do_reset(1'b0, 1'b1);
        chk("R1 active", dbg_active, 1);
        chk("R1 enabled", dbg_enabled, 1);
        chk("R1 fw_ok", fw_cmd_ok, 1);

        // R11 R12 address window table, unit active
        user_rd_en = 1'b1;
        foreach (VEC[i]) begin
            user_rd_addr = VEC[i][19:2];
            dbg_rd_addr = VEC[i][19:2];
            #1;
            chk("R12 reg hit", dbg_reg_hit, VEC[i][1]);
            chk("R11 user block", user_rd_block, VEC[i][0]);
        end
        user_rd_en = 1'b0;
        user_rd_addr = 18'h3FF04;
        #1;
        chk("R11 no read no block", user_rd_block, 0);

        // R13 leave debug mode
        host_go = 1'b1;
        step();
        host_go = 1'b0;
        chk("R13 go clears active", dbg_active, 0);
        user_rd_en = 1'b1;
        #1;
        chk("R11 inactive no block", user_rd_block, 0);
        user_rd_en = 1'b0;

        // R1 normal reset
        do_reset(1'b0, 1'b0);
        chk("R1 normal active", dbg_active, 0);
        chk("R1 normal enabled", dbg_enabled, 0);
        chk("R1 normal stall", cpu_stall, 0);
        chk("R1 normal enter", enter_pulse, 0);

        // R3 disabled host and breakpoint requests dropped
        host_bgnd = 1'b1;
        brk_req = 1'b1;
        insn_done = 1'b1;
        step();
        host_bgnd = 1'b0;
        brk_req = 1'b0;
        insn_done = 1'b0;
        chk("R3 no activation", dbg_active, 0);
        chk("R3 no stall", cpu_stall, 0);
        step();
        chk("R3 still inactive", dbg_active, 0);

        // R4 disabled CPU background instruction stalls
        cpu_bgnd = 1'b1;
        step();
        cpu_bgnd = 1'b0;
        begin
            int n = 0;
            while (cpu_stall && n < 100) begin
                n++;
                step();
            end
            chk("R4 stall length", n, 16);
        end
        chk("R4 no activation", dbg_active, 0);

        // R2 register writes
        wr_sts(4'h2, 8'hFF);
        chk("R2 wrong offset ignored", dbg_enabled, 0);
        wr_sts(4'h1, 8'hC0);
        chk("R2 enable set", dbg_enabled, 1);
        chk("R2 unsec not writable", unsec_bit, 0);
        wr_sts(4'h1, 8'h00);
        chk("R2 enable clear", dbg_enabled, 0);
        wr_sts(4'h1, 8'h80);

        // R5 request held pending until instruction boundary
        host_bgnd = 1'b1;
        step();
        host_bgnd = 1'b0;
        chk("R5 pending not active", dbg_active, 0);
        step();
        chk("R5 still waiting", dbg_active, 0);
        insn_done = 1'b1;
        cpu_pc = 18'h01234;
        step();
        insn_done = 1'b0;
        chk("R5 active at boundary", dbg_active, 1);
        chk("R5 enter pulse", enter_pulse, 1);
        chk("R7 pc outside range", saved_pc, 18'h01234);
        step();
        chk("R5 pulse one cycle", enter_pulse, 0);
        host_go = 1'b1;
        step();
        host_go = 1'b0;
        chk("R13 go exits", dbg_active, 0);

        // R6 merged requests, R7 firmware range
        host_bgnd = 1'b1;
        cpu_bgnd = 1'b1;
        brk_req = 1'b1;
        insn_done = 1'b1;
        cpu_pc = 18'h3FF20;
        step();
        chk("R6 single entry", enter_pulse, 1);
        chk("R7 pc incremented", saved_pc, 18'h3FF21);
        chk("R4 enabled bgnd no stall", cpu_stall, 0);
        begin
            int pulses = 0;
            for (int k = 0; k < 3; k++) begin
                step();
                if (enter_pulse) pulses++;
            end
            chk("R6 no repeat entry", pulses, 0);
        end
        host_bgnd = 1'b0;
        cpu_bgnd = 1'b0;
        brk_req = 1'b0;
        insn_done = 1'b0;
        host_go = 1'b1;
        step();
        host_go = 1'b0;
        brk_req = 1'b1;
        insn_done = 1'b1;
        cpu_pc = 18'h3FF0B;
        step();
        chk("R7 register edge not incremented", saved_pc, 18'h3FF0B);
        brk_req = 1'b0;
        insn_done = 1'b0;
        host_go = 1'b1;
        step();
        host_go = 1'b0;
        cpu_bgnd = 1'b1;
        insn_done = 1'b1;
        cpu_pc = 18'h3FF0C;
        step();
        cpu_bgnd = 1'b0;
        insn_done = 1'b0;
        chk("R7 firmware low edge", saved_pc, 18'h3FF0D);

        // R8 secured special, both blank
        do_reset(1'b1, 1'b1);
        chk("R8 not enabled before verify", dbg_enabled, 0);
        chk("R8 hw blocked before verify", hw_cmd_ok, 0);
        ev_done = 1'b1;
        ev_ok_eeprom = 1'b1;
        ev_ok_flash = 1'b1;
        step();
        ev_done = 1'b0;
        chk("R8 enabled", dbg_enabled, 1);
        chk("R8 unsec", unsec_bit, 1);
        chk("R8 fw ok", fw_cmd_ok, 1);

        // R9 secured special, flash not blank
        do_reset(1'b1, 1'b1);
        ev_done = 1'b1;
        ev_ok_eeprom = 1'b1;
        ev_ok_flash = 1'b0;
        step();
        ev_done = 1'b0;
        chk("R9 enabled", dbg_enabled, 1);
        chk("R9 unsec clear", unsec_bit, 0);
        chk("R9 hw ok", hw_cmd_ok, 1);
        chk("R9 fw blocked", fw_cmd_ok, 0);
        host_go = 1'b1;
        step();
        host_go = 1'b0;
        chk("R9 go ignored", dbg_active, 1);

        // R10 secured normal mode
        do_reset(1'b1, 1'b0);
        wr_sts(4'h1, 8'h80);
        chk("R10 write ignored", dbg_enabled, 0);
        chk("R10 hw blocked", hw_cmd_ok, 0);
        host_bgnd = 1'b1;
        insn_done = 1'b1;
        step();
        host_bgnd = 1'b0;
        insn_done = 1'b0;
        chk("R10 request dropped", dbg_active, 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule